// File: doc/BRIEF.md
# Potentiometer Wiper Position Counter with One-Hot Tap Select

This block keeps the wiper position of one digitally controlled potentiometer and turns it into the switch enables of a 64-tap resistor string. Exactly one switch is closed at a time. Position 00h closes the switch at the low end of the string, and position 3Fh closes the switch at the high end. A chip with several potentiometers uses one instance per potentiometer. The resistor string itself and the nonvolatile data registers sit outside this block.

The position is a volatile register with four load paths:
- **Recall.** A one-time recall of data register 0 when the chip powers up.
- **Host write.** A value supplied by the host over the serial bus.
- **Register transfer.** A parallel transfer from whichever data register the command decoder selected.
- **Single steps.** Steps up or down, one segment per strobe.

The recall, host and register paths are valid/ready inputs. A path's value is taken on a clock edge where both its valid and its ready are high. The recall port is ready only until its first transfer and never again. The host and register ports are ready only after that first transfer. The register port is also held not-ready in any cycle in which the host port is valid, which makes the host the winner. Upstream logic must hold its value stable while valid is high and ready is low. The step strobes are plain control inputs.

Every change of position starts a settle timer. The timer length comes from the `settle_cycles` input and is sampled in the cycle of the change. The tap enables follow the new position only once that timer runs out, so the analog response time is modelled in clock cycles. The current position is always readable on `wiper_pos`.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: After reset:
  - `wiper_pos` is 0 and `tap_en` is all zero.
  - `recall_ready` is 1.
  - `host_ready` and `dreg_ready` are 0.
- R2: The first recall handshake loads `recall_pos` into `wiper_pos` on that edge. After it, `recall_ready` stays 0 and later recall values are ignored.
- R3: Once the first settle period has ended, `tap_en` always has exactly one bit set. Bit index i means position i, so bit 0 is the low terminal (00h) and bit 63 is the high terminal (3Fh).
- R4: After recall, `host_ready` is 1. A host handshake loads `host_pos` into `wiper_pos` on that edge.
- R5: After recall, a register-port handshake loads `dreg_pos`. `dreg_ready` is 0 whenever `host_valid` is 1, so a host write wins and the register value is not taken.
- R6: With no load in the cycle, `step_up` alone adds one and `step_dn` alone subtracts one. A step up at 3Fh leaves the position at 3Fh, and a step down at 00h leaves it at 00h.
- R7: A step strobe in a cycle where any load is accepted is ignored, and the loaded value is kept.
- R8: A change of position on edge k makes `tap_en` show the new position on edge k+N+1, where N is `settle_cycles` in the cycle of the change. Until then `tap_en` keeps its old value. A further change before the update restarts the count.
- R9: Before recall, host writes, register loads and steps have no effect. `tap_en` stays all zero until the recall has settled.
- R10: `step_up` and `step_dn` together in the same cycle leave the position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| settle_cycles | input | 8 | Settle delay in cycles, sampled when the position changes |
| recall_valid | input | 1 | Power-up recall value valid |
| recall_ready | output | 1 | Recall port accepts (only before the first recall) |
| recall_pos | input | 6 | Value of data register 0 |
| host_valid | input | 1 | Host write valid |
| host_ready | output | 1 | Host port accepts |
| host_pos | input | 6 | Host-written position |
| dreg_valid | input | 1 | Data-register transfer valid |
| dreg_ready | output | 1 | Data-register port accepts |
| dreg_pos | input | 6 | Selected data register contents |
| step_up | input | 1 | One-segment step toward the high terminal |
| step_dn | input | 1 | One-segment step toward the low terminal |
| wiper_pos | output | 6 | Current position (read port) |
| tap_en | output | 64 | One-hot switch enables, bit 0 = low terminal |

## Verification
The assertions check on every cycle that:
- at most one tap enable is set, and none is set before recall;
- a host handshake wins over every other source on the next edge;
- unsaturated steps move by exactly one, and saturated steps stay put;
- the recall flag never clears;
- the tap vector holds still while the settle count runs.

Only the bench scenarios can show the rest:
- the exact edge on which the tap vector catches up after N settle cycles, and the restart when a change arrives mid-count;
- that register loads lose to a simultaneous host write;
- that inputs given before recall leave no trace once the block is live.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_RECALL = 2'd1,
    SRC_HOST   = 2'd2,
    SRC_DREG   = 2'd3
  } load_src_e;

  typedef enum logic [1:0] {
    MOVE_HOLD = 2'd0,
    MOVE_UP   = 2'd1,
    MOVE_DN   = 2'd2
  } move_e;
endpackage

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
  import wiper_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recall_valid,
  input  logic [POS_W-1:0] recall_pos,
  input  logic             host_valid,
  input  logic [POS_W-1:0] host_pos,
  input  logic             dreg_valid,
  input  logic [POS_W-1:0] dreg_pos,
  input  logic             step_up,
  input  logic             step_dn,
  output logic             recall_ready,
  output logic             host_ready,
  output logic             dreg_ready,
  output logic             live,
  output logic             change,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic [POS_W-1:0] pos_q, pos_d;
  logic             live_q;
  load_src_e        src;
  move_e            mv;

  assign recall_ready = !live_q;
  assign host_ready   = live_q;
  assign dreg_ready   = live_q && !host_valid;

  always_comb begin
    if (!live_q && recall_valid)      src = SRC_RECALL;
    else if (live_q && host_valid)    src = SRC_HOST;
    else if (live_q && dreg_valid)    src = SRC_DREG;
    else                              src = SRC_NONE;
  end

  always_comb begin
    mv = MOVE_HOLD;
    if (live_q && src == SRC_NONE) begin
      if (step_up && !step_dn && pos_q != POS_MAX)      mv = MOVE_UP;
      else if (step_dn && !step_up && pos_q != POS_MIN) mv = MOVE_DN;
    end
  end

  always_comb begin
    unique case (src)
      SRC_RECALL: pos_d = recall_pos;
      SRC_HOST:   pos_d = host_pos;
      SRC_DREG:   pos_d = dreg_pos;
      default: begin
        unique case (mv)
          MOVE_UP: pos_d = pos_q + POS_W'(1);
          MOVE_DN: pos_d = pos_q - POS_W'(1);
          default: pos_d = pos_q;
        endcase
      end
    endcase
  end

  assign change = (src != SRC_NONE) || (mv != MOVE_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      live_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      if (src == SRC_RECALL) live_q <= 1'b1;
    end
  end

  assign pos  = pos_q;
  assign live = live_q;

  a_r2_recall_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |=> live_q);
  a_r4_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && host_valid) |=> (pos_q == $past(host_pos)));
  a_r6_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !host_valid && !dreg_valid && step_up && !step_dn && pos_q != POS_MAX)
      |=> (pos_q == $past(pos_q) + POS_W'(1)));
  a_r6_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !host_valid && !dreg_valid && step_up && pos_q == POS_MAX) |=> (pos_q == POS_MAX));
  a_r6_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !host_valid && !dreg_valid && step_dn && pos_q == POS_MIN) |=> (pos_q == POS_MIN));
  a_r9_idle_before_recall: assert property (@(posedge clk) disable iff (!rst_n)
    (!live_q && !recall_valid) |=> $stable(pos_q));
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] delay,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  assign fire = pend_q && (cnt_q == '0) && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= delay;
      pend_q <= 1'b1;
    end else if (pend_q) begin
      if (cnt_q == '0) pend_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cnt_q != '0 && !start) |=> (pend_q && cnt_q == $past(cnt_q) - CNT_W'(1)));
  a_r8_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pend_q);
endmodule

// File: rtl/tap_decoder.sv
module tap_decoder #(
  parameter int POS_W = 6,
  localparam int TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             update,
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap_en
);
  logic [TAPS-1:0] tap_q;

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tap_q[t] <= 1'b0;
      else if (update) tap_q[t] <= (pos == POS_W'(t));
    end
  end

  assign tap_en = tap_q;

  a_r3_one_switch_max: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tap_q));
  a_r3_tap_matches: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> (tap_q[$past(pos)] && $countones(tap_q) == 1));
  a_r8_hold_while_settling: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(tap_q));
endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl #(
  parameter int POS_W = 6,
  parameter int CNT_W = 8,
  localparam int TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic             recall_valid,
  output logic             recall_ready,
  input  logic [POS_W-1:0] recall_pos,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic [POS_W-1:0] host_pos,
  input  logic             dreg_valid,
  output logic             dreg_ready,
  input  logic [POS_W-1:0] dreg_pos,
  input  logic             step_up,
  input  logic             step_dn,
  output logic [POS_W-1:0] wiper_pos,
  output logic [TAPS-1:0]  tap_en
);
  logic live, change, fire;

  wiper_pos_reg #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n),
    .recall_valid(recall_valid), .recall_pos(recall_pos),
    .host_valid(host_valid), .host_pos(host_pos),
    .dreg_valid(dreg_valid), .dreg_pos(dreg_pos),
    .step_up(step_up), .step_dn(step_dn),
    .recall_ready(recall_ready), .host_ready(host_ready), .dreg_ready(dreg_ready),
    .live(live), .change(change), .pos(wiper_pos)
  );

  settle_timer #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(change), .delay(settle_cycles), .fire(fire)
  );

  tap_decoder #(.POS_W(POS_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .update(fire), .pos(wiper_pos), .tap_en(tap_en)
  );

  a_r9_dark_before_recall: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> (tap_en == '0));
  a_r5_host_blocks_dreg: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |-> !dreg_ready);
endmodule

// File: tb/test_wiper_tap_ctrl.sv
module test_wiper_tap_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  settle_cycles = 0;
  logic        recall_valid = 0, host_valid = 0, dreg_valid = 0;
  logic [5:0]  recall_pos = 0, host_pos = 0, dreg_pos = 0;
  logic        step_up = 0, step_dn = 0;
  logic        recall_ready, host_ready, dreg_ready;
  logic [5:0]  wiper_pos;
  logic [63:0] tap_en;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // bench model
  bit          m_live = 0, m_pend = 0;
  int          m_pos = 0, m_cnt = 0;
  logic [63:0] m_tap = '0;

  always #4 clk = ~clk;

  wiper_tap_ctrl i_wiper_tap_ctrl (
    .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles),
    .recall_valid(recall_valid), .recall_ready(recall_ready), .recall_pos(recall_pos),
    .host_valid(host_valid), .host_ready(host_ready), .host_pos(host_pos),
    .dreg_valid(dreg_valid), .dreg_ready(dreg_ready), .dreg_pos(dreg_pos),
    .step_up(step_up), .step_dn(step_dn), .wiper_pos(wiper_pos), .tap_en(tap_en)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      summary();
    end
  end

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at the edge, compare at next negedge
  task automatic tick(string tag, bit rv, int rp, bit hv, int hp, bit dv, int dp,
                      bit up, bit dn, int st);
    bit chg;
    int np;
    recall_valid = rv; recall_pos = 6'(rp);
    host_valid = hv; host_pos = 6'(hp);
    dreg_valid = dv; dreg_pos = 6'(dp);
    step_up = up; step_dn = dn; settle_cycles = 8'(st);
    #1;
    cmp({tag, " R2 recall_ready"}, 64'(recall_ready), 64'(!m_live));
    cmp({tag, " R4 host_ready"}, 64'(host_ready), 64'(m_live));
    cmp({tag, " R5 dreg_ready"}, 64'(dreg_ready), 64'(m_live && !hv));
    @(posedge clk);
    chg = 0; np = m_pos;
    if (!m_live) begin
      if (rv) begin np = rp; chg = 1; m_live = 1; end
    end else if (hv) begin np = hp; chg = 1; end
    else if (dv) begin np = dp; chg = 1; end
    else if (up && !dn && m_pos < 63) begin np = m_pos + 1; chg = 1; end
    else if (dn && !up && m_pos > 0) begin np = m_pos - 1; chg = 1; end
    if (chg) begin m_pend = 1; m_cnt = st; end
    else if (m_pend) begin
      if (m_cnt == 0) begin m_tap = 64'd1 << m_pos; m_pend = 0; end
      else m_cnt--;
    end
    m_pos = np;
    @(negedge clk);
    cmp({tag, " wiper_pos"}, 64'(wiper_pos), 64'(m_pos));
    cmp({tag, " R3 R8 tap_en"}, tap_en, m_tap);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) tick(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int sd;
    sd = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    cmp("R1 pos", 64'(wiper_pos), 0);
    cmp("R1 tap", tap_en, 0);
    cmp("R1 recall_ready", 64'(recall_ready), 1);
    cmp("R1 host_ready", 64'(host_ready), 0);
    rst_n = 1;
    @(negedge clk);
    // R9: loads and steps before recall are ignored
    tick("R9 host", 0, 0, 1, 20, 0, 0, 0, 0, 0);
    tick("R9 dreg", 0, 0, 0, 0, 1, 9, 0, 0, 0);
    tick("R9 step", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    cmp("R9 tap dark", tap_en, 0);
    // R2 recall with settle 3: tap dark for 3 cycles then on
    tick("R2 recall", 1, 62, 0, 0, 0, 0, 0, 0, 3);
    idle("R8 settle", 5);
    cmp("R3 tap bit62", tap_en, 64'd1 << 62);
    tick("R2 second recall", 1, 5, 0, 0, 0, 0, 0, 0, 0);
    // R6 saturation at the top
    tick("R6 up", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    tick("R6 up sat", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    idle("R6 idle", 2);
    cmp("R3 high terminal", tap_en, 64'd1 << 63);
    tick("R10 both", 0, 0, 0, 0, 0, 0, 1, 1, 0);
    // R5 host beats dreg, R7 load beats step
    tick("R5 host+dreg", 0, 0, 1, 1, 1, 40, 0, 0, 0);
    tick("R7 load+step", 0, 0, 0, 0, 1, 0, 1, 0, 0);
    tick("R6 dn sat", 0, 0, 0, 0, 0, 0, 0, 1, 2);
    idle("R6 idle", 3);
    cmp("R3 low terminal", tap_en, 64'd1);
    // R8 restart: change mid-count
    tick("R8 first", 0, 0, 1, 10, 0, 0, 0, 0, 4);
    idle("R8 mid", 2);
    tick("R8 restart", 0, 0, 0, 0, 1, 30, 0, 0, 4);
    idle("R8 wait", 6);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k, v;
      k = $urandom_range(0, 9);
      v = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) == 1) ? 63 : 0)
                                      : $urandom_range(0, 63);
      tick("RND R4 R5 R6 R7 R10", $urandom_range(0, 1), v,
           k == 0, v, k == 1 || k == 2, $urandom_range(0, 63),
           k >= 3 && k <= 6, k >= 5 && k <= 8, $urandom_range(0, 4));
    end
    idle("end", 8);
    done = 1;
    summary();
  end
endmodule